// File: doc/BRIEF.md
# Prioritized interrupt request core

This block arbitrates among eight interrupt request lines on behalf of a CPU. It keeps three pieces of per-level state: which levels are asking for service (pending), which are currently being serviced (in-service), and which are blocked by software (mask, supplied as an input). When an unmasked pending level outranks every level already in service, the block raises its interrupt output. Level 0 has the highest priority and level 7 the lowest.

The CPU answers with two acknowledge pulses. The first pulse moves the winning level from pending to in-service and leaves the bus idle. The second pulse drives an 8-bit vector whose upper five bits come from a programmed base and whose lower three bits encode the level. An in-service bit is cleared either automatically when the second pulse ends or later by an end-of-interrupt strobe, which always releases the highest-priority level still in service. Request and acknowledge inputs are asynchronous. They pass through a synchronizer before the core acts on them.

Top module: `irq_prio_core`

## Requirements
- R1: After reset, `int_o` is 0, `isr_o` is 0, `vec_oe_o` is 0 and `vec_o` is 0.
- R2: A 0-to-1 transition on `irq_i[n]` sets pending bit n. A pending bit is cleared again if its line returns to 0 before it is acknowledged.
- R3: Outside an acknowledge sequence, `int_o` is 1 exactly when some unmasked pending level has a smaller index than every set `isr_o` bit (or `isr_o` is 0). Otherwise it is 0.
- R4: On the first acknowledge pulse, the lowest-index unmasked pending level sets its `isr_o` bit and its pending bit clears. `vec_oe_o` stays 0 during this pulse.
- R5: While the second acknowledge pulse is high, `vec_oe_o` is 1 and `vec_o` = {`vec_base_i`[4:0], level[2:0]}. Whenever `vec_oe_o` is 0, `vec_o` is 0.
- R6: If no unmasked level is pending at the first pulse, the sequence answers with level 7 (`vec_o[2:0]` = 3'b111) and `isr_o` is left unchanged.
- R7: With `auto_eoi_i` = 1, the acknowledged `isr_o` bit clears when the second pulse ends. With `auto_eoi_i` = 0, it stays set.
- R8: A one-cycle `eoi_i` strobe clears the lowest-index set bit of `isr_o`.
- R9: `int_o` holds its value from the first pulse until the second pulse ends. It is then 0 for exactly one clock and is re-evaluated by R3. A higher-priority request that arrives between the pulses therefore raises `int_o` again one clock after the sequence.
- R10: A set `mask_i[n]` blocks only level n. Lower-priority unmasked levels still raise `int_o` and win acknowledge.
- R11: `irq_i` and `ack_i` pass through SYNC_STAGES (default 2) flops. A request edge raises `int_o` on the fourth rising clock after it is applied, and acknowledge acts only on its synchronized edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 8 | Asynchronous request lines, index 0 highest priority |
| ack_i | input | 1 | Asynchronous acknowledge strobe from the CPU, active high |
| mask_i | input | 8 | Per-level block, 1 = level blocked |
| vec_base_i | input | 5 | Upper bits of the vector byte |
| auto_eoi_i | input | 1 | 1 = clear in-service automatically at the end of the second pulse |
| eoi_i | input | 1 | Synchronous one-cycle end-of-interrupt command |
| int_o | output | 1 | Interrupt request toward the CPU |
| vec_o | output | 8 | Vector byte, zero when not driven |
| vec_oe_o | output | 1 | Bus-drive enable for `vec_o` |
| isr_o | output | 8 | In-service bits |

## Verification
The bench builds the core with its defaults: eight levels, an 8-bit vector and a two-flop synchronizer. With these values the level-7 default answer shares an encoding with a genuine level-7 request, and every level number fills the three vector bits. The short synchronizer lets a full two-pulse handshake, including a preemption between the pulses, fit in a few dozen clocks. A behavioural model advances with the same pin-to-action latency and is compared on every clock. Directed scenarios cover nested service, masking, spurious acknowledge, automatic end-of-interrupt and mid-handshake preemption.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    // Acknowledge handshake position
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_GAP   = 2'd1,
        PH_DRIVE = 2'd2
    } ack_phase_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    // Lowest index wins
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign valid_o = |vec_i;

endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
    import irq_prio_pkg::*;
#(
    parameter int NUM_LEVELS  = 8,
    parameter int VEC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_LEVELS-1:0]                 irq_i,
    input  logic                                  ack_i,
    input  logic [NUM_LEVELS-1:0]                 mask_i,
    input  logic [VEC_W-$clog2(NUM_LEVELS)-1:0]   vec_base_i,
    input  logic                                  auto_eoi_i,
    input  logic                                  eoi_i,
    output logic                                  int_o,
    output logic [VEC_W-1:0]                      vec_o,
    output logic                                  vec_oe_o,
    output logic [NUM_LEVELS-1:0]                 isr_o
);

    localparam int LVL_W  = $clog2(NUM_LEVELS);
    localparam int BASE_W = VEC_W - LVL_W;
    localparam logic [LVL_W-1:0]      DEF_LVL = LVL_W'(NUM_LEVELS - 1);
    localparam logic [NUM_LEVELS-1:0] ONE_HOT = NUM_LEVELS'(1);

    typedef struct packed {
        logic [NUM_LEVELS-1:0] irr;
        logic [NUM_LEVELS-1:0] isr;
        logic [NUM_LEVELS-1:0] req_prev;
        logic                  ack_prev;
        ack_phase_e            phase;
        logic [LVL_W-1:0]      lvl;
        logic                  spur;
        logic                  intr;
    } core_st_t;

    core_st_t st_d, st_q;

    // Synchronized inputs
    logic [NUM_LEVELS-1:0] req_s;
    logic                  ack_s;

    irq_sync #(
        .WIDTH  (NUM_LEVELS + 1),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ack_i, irq_i}),
        .q_o   ({ack_s, req_s})
    );

    // Priority resolution over pending and in-service sets
    logic [NUM_LEVELS-1:0] eligible;
    logic                  win_v;
    logic [LVL_W-1:0]      win_idx;
    logic                  svc_v;
    logic [LVL_W-1:0]      svc_idx;

    assign eligible = st_q.irr & ~mask_i;

    irq_first_set #(.N(NUM_LEVELS), .IDX_W(LVL_W)) req_pick_i (
        .vec_i   (eligible),
        .valid_o (win_v),
        .idx_o   (win_idx)
    );

    irq_first_set #(.N(NUM_LEVELS), .IDX_W(LVL_W)) svc_pick_i (
        .vec_i   (st_q.isr),
        .valid_o (svc_v),
        .idx_o   (svc_idx)
    );

    logic ack_rise, ack_fall;
    logic first_pulse, second_pulse, end_pulse;
    logic raise;

    assign ack_rise     = ack_s & ~st_q.ack_prev;
    assign ack_fall     = ~ack_s & st_q.ack_prev;
    assign first_pulse  = ack_rise && (st_q.phase == PH_IDLE);
    assign second_pulse = ack_rise && (st_q.phase == PH_GAP);
    assign end_pulse    = ack_fall && (st_q.phase == PH_DRIVE);
    assign raise        = win_v && (!svc_v || (win_idx < svc_idx));

    logic [NUM_LEVELS-1:0] set_vec, clr_vec, irr_nx;

    always_comb begin
        st_d          = st_q;
        st_d.req_prev = req_s;
        st_d.ack_prev = ack_s;
        set_vec       = '0;
        clr_vec       = '0;
        // Edge sets pending; a dropped line withdraws it
        irr_nx        = (st_q.irr | (req_s & ~st_q.req_prev)) & req_s;

        if (first_pulse) begin
            st_d.phase = PH_GAP;
            if (win_v) begin
                st_d.lvl  = win_idx;
                st_d.spur = 1'b0;
                set_vec   = ONE_HOT << win_idx;
            end else begin
                st_d.lvl  = DEF_LVL;
                st_d.spur = 1'b1;
            end
        end else if (second_pulse) begin
            st_d.phase = PH_DRIVE;
        end

        if (end_pulse) begin
            st_d.phase = PH_IDLE;
            st_d.intr  = 1'b0;
            if (auto_eoi_i && !st_q.spur) begin
                clr_vec = ONE_HOT << st_q.lvl;
            end
        end else if ((st_q.phase == PH_IDLE) && !first_pulse) begin
            st_d.intr = raise;
        end

        if (eoi_i && svc_v) begin
            clr_vec = clr_vec | (ONE_HOT << svc_idx);
        end

        st_d.irr = irr_nx & ~set_vec;
        st_d.isr = (st_q.isr | set_vec) & ~clr_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign int_o    = st_q.intr;
    assign vec_oe_o = (st_q.phase == PH_DRIVE);
    assign vec_o    = vec_oe_o ? {vec_base_i[BASE_W-1:0], st_q.lvl} : '0;
    assign isr_o    = st_q.isr;

endmodule

// File: rtl/irq_prio_core_chk.sv
module irq_prio_core_chk #(
    parameter int NUM_LEVELS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  int_o,
    input logic                  vec_oe_o,
    input logic [NUM_LEVELS-1:0] isr_o,
    input logic                  eoi_i,
    input logic                  auto_eoi_i,
    input logic                  first_pulse,
    input logic                  end_pulse
);

    // R9
    int_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vec_oe_o) |-> !int_o);

    // R9
    int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe_o |-> $stable(int_o));

    // R4
    first_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_pulse |=> !vec_oe_o);

    // R8
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && (isr_o != '0) && !first_pulse && !end_pulse)
        |=> ($countones(isr_o) + 1 == $countones($past(isr_o))));

    // R7
    isr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_pulse && !auto_eoi_i && !eoi_i) |=> (isr_o == $past(isr_o)));

endmodule

bind irq_prio_core irq_prio_core_chk #(.NUM_LEVELS(NUM_LEVELS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_o       (int_o),
    .vec_oe_o    (vec_oe_o),
    .isr_o       (isr_o),
    .eoi_i       (eoi_i),
    .auto_eoi_i  (auto_eoi_i),
    .first_pulse (first_pulse),
    .end_pulse   (end_pulse)
);

// File: tb/irq_prio_core_tb_top.sv
module irq_prio_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_i = '0;
    logic       ack_i = 1'b0;
    logic [7:0] mask_i = '0;
    logic [4:0] vec_base_i = 5'b10100;
    logic       auto_eoi_i = 1'b0;
    logic       eoi_i = 1'b0;
    logic       int_o;
    logic [7:0] vec_o;
    logic       vec_oe_o;
    logic [7:0] isr_o;

    int n_checks = 0;
    int n_errors = 0;
    bit model_live = 0;

    always #5 clk = ~clk;

    irq_prio_core dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .ack_i(ack_i), .mask_i(mask_i),
        .vec_base_i(vec_base_i), .auto_eoi_i(auto_eoi_i), .eoi_i(eoi_i),
        .int_o(int_o), .vec_o(vec_o), .vec_oe_o(vec_oe_o), .isr_o(isr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: two-flop delay, then pending/service rules
    logic [7:0] m_s1, m_s2, m_rp, m_irr, m_isr;
    logic       m_a1, m_a2, m_ap, m_spur, m_int;
    int         m_ph, m_lvl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_rp = 0; m_irr = 0; m_isr = 0;
            m_a1 = 0; m_a2 = 0; m_ap = 0; m_spur = 0; m_int = 0;
            m_ph = 0; m_lvl = 0;
        end else begin
            logic [7:0] req, el, n_irr, n_isr;
            logic ack, rising, falling, n_int, n_spur;
            int win, top, n_ph, n_lvl;
            req = m_s2; ack = m_a2;
            el = m_irr & ~mask_i;
            win = -1; top = -1;
            for (int i = 7; i >= 0; i--) begin
                if (el[i]) win = i;
                if (m_isr[i]) top = i;
            end
            n_irr = (m_irr | (req & ~m_rp)) & req;
            n_isr = m_isr; n_int = m_int; n_ph = m_ph; n_lvl = m_lvl; n_spur = m_spur;
            rising = ack && !m_ap;
            falling = !ack && m_ap;
            if (rising && m_ph == 0) begin
                n_ph = 1;
                if (win >= 0) begin
                    n_lvl = win; n_spur = 0; n_isr[win] = 1'b1; n_irr[win] = 1'b0;
                end else begin
                    n_lvl = 7; n_spur = 1;
                end
            end else if (rising && m_ph == 1) begin
                n_ph = 2;
            end
            if (falling && m_ph == 2) begin
                n_ph = 0; n_int = 0;
                if (auto_eoi_i && !m_spur) n_isr[m_lvl] = 1'b0;
            end else if (m_ph == 0 && !rising) begin
                n_int = (win >= 0) && (top < 0 || win < top);
            end
            if (eoi_i && top >= 0) n_isr[top] = 1'b0;
            m_irr = n_irr; m_isr = n_isr; m_int = n_int;
            m_ph = n_ph; m_lvl = n_lvl; m_spur = n_spur;
            m_rp = req; m_ap = ack;
            m_s2 = m_s1; m_s1 = irq_i; m_a2 = m_a1; m_a1 = ack_i;
        end
        model_live = 1;
    end

    always @(negedge clk) begin
        if (model_live) begin
            chk("R3 int_o vs model", 32'(int_o), 32'(m_int));
            chk("R4 isr_o vs model", 32'(isr_o), 32'(m_isr));
            chk("R5 vec_oe_o vs model", 32'(vec_oe_o), 32'(m_ph == 2));
            chk("R5 vec_o vs model", 32'(vec_o),
                (m_ph == 2) ? 32'({vec_base_i, 3'(m_lvl)}) : 32'd0);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_first();
        ack_i = 1'b1; tick(4);
        chk("R4 bus idle in first pulse", 32'(vec_oe_o), 32'd0);
        ack_i = 1'b0; tick(4);
    endtask

    // Ends three clocks after release: int_o is in its one-clock drop
    task automatic ack_second(output logic [7:0] v, output logic oe);
        ack_i = 1'b1; tick(4);
        v = vec_o; oe = vec_oe_o;
        ack_i = 1'b0; tick(3);
    endtask

    task automatic eoi_pulse();
        eoi_i = 1'b1; tick(1);
        eoi_i = 1'b0; tick(1);
    endtask

    logic [7:0] v;
    logic       oe;

    initial begin
        tick(3);
        chk("R1 int_o reset", 32'(int_o), 32'd0);
        chk("R1 isr_o reset", 32'(isr_o), 32'd0);
        chk("R1 vec_oe_o reset", 32'(vec_oe_o), 32'd0);
        chk("R1 vec_o reset", 32'(vec_o), 32'd0);
        rst_n = 1'b1;
        tick(2);

        // R2 R11: latency of a request edge to int_o
        irq_i[3] = 1'b1;
        tick(3);
        chk("R11 int_o not yet", 32'(int_o), 32'd0);
        tick(1);
        chk("R2 int_o after edge", 32'(int_o), 32'd1);

        // R4 R5 R7: plain handshake, fully nested
        ack_first();
        chk("R4 isr after first", 32'(isr_o), 32'h08);
        ack_second(v, oe);
        chk("R5 vector level 3", 32'(v), 32'hA3);
        chk("R5 oe in second", 32'(oe), 32'd1);
        tick(2);
        chk("R7 isr kept", 32'(isr_o), 32'h08);
        chk("R3 int low after service", 32'(int_o), 32'd0);

        // R3: lower priority than in-service stays quiet
        irq_i[5] = 1'b1; tick(6);
        chk("R3 lower level blocked", 32'(int_o), 32'd0);

        // R10: mask level 1, level 2 still gets through
        mask_i = 8'h02;
        irq_i[1] = 1'b1; tick(6);
        chk("R10 masked level silent", 32'(int_o), 32'd0);
        irq_i[2] = 1'b1; tick(6);
        chk("R10 next level raises", 32'(int_o), 32'd1);
        ack_first();
        ack_second(v, oe);
        chk("R10 vector level 2", 32'(v), 32'hA2);
        tick(2);
        chk("R10 isr nested", 32'(isr_o), 32'h0C);

        // R8: EOI releases the highest-priority service first
        eoi_pulse();
        chk("R8 first eoi", 32'(isr_o), 32'h08);
        chk("R8 int still low", 32'(int_o), 32'd0);
        eoi_pulse();
        chk("R8 second eoi", 32'(isr_o), 32'h00);
        chk("R8 int after release", 32'(int_o), 32'd1);

        // R6 R2: request withdrawn before acknowledge
        irq_i = '0; mask_i = '0; tick(6);
        chk("R2 withdrawn request", 32'(int_o), 32'd0);
        ack_first();
        ack_second(v, oe);
        chk("R6 default level 7", 32'(v), 32'hA7);
        tick(2);
        chk("R6 isr untouched", 32'(isr_o), 32'h00);

        // R7: automatic end-of-interrupt
        auto_eoi_i = 1'b1;
        irq_i[4] = 1'b1; tick(6);
        ack_first();
        chk("R7 isr set", 32'(isr_o), 32'h10);
        ack_second(v, oe);
        chk("R7 vector level 4", 32'(v), 32'hA4);
        tick(2);
        chk("R7 auto cleared", 32'(isr_o), 32'h00);
        irq_i = '0; auto_eoi_i = 1'b0; tick(4);

        // R9: preemption between the two pulses
        irq_i[6] = 1'b1; tick(6);
        ack_first();
        irq_i[0] = 1'b1; tick(6);
        chk("R9 int held in gap", 32'(int_o), 32'd1);
        ack_second(v, oe);
        chk("R9 vector level 6", 32'(v), 32'hA6);
        chk("R9 int dropped", 32'(int_o), 32'd0);
        tick(1);
        chk("R9 int back one clock later", 32'(int_o), 32'd1);
        ack_first();
        ack_second(v, oe);
        chk("R9 vector level 0", 32'(v), 32'hA0);
        tick(2);
        chk("R9 isr both", 32'(isr_o), 32'h41);

        tick(4);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule